// File: doc/BRIEF.md
# Peripheral Bus Access Monitor

This block sits between the load/store port of a processor and a region of memory-mapped peripherals. It watches every access to that region. A read, or a full-word write, is passed to the peripheral as a single-cycle strobe in the cycle it is requested. The monitor then waits for the peripheral to answer with an acknowledge or an error.

Each access ends with exactly one result pulse. A done pulse means success. A load-fault pulse means a read failed, and a store-fault pulse means a write failed. A failure is either an error answer from the peripheral or no answer within a fixed number of cycles. A write whose byte-enable mask is not all ones is never forwarded and is faulted at once. Reads are always word-wide on the bus, so their byte-enable mask is ignored.

Only one access may be outstanding at a time. While an access waits, the busy output is high and new requests are not accepted. Decoding which addresses belong to the region, moving data and raising the exception itself are left to the surrounding logic.

Top module: `periph_access_monitor`

## Requirements
- R1: In the idle state, a read request or a write request with byteEn = 4'b1111 drives perRd or perWr high in the same cycle. busy is high in the next cycle.
- R2: perAck seen while busy (with perErr low) gives a one-cycle done pulse in the next cycle. busy is low in that cycle.
- R3: The request cycle counts as cycle 1 of the access. With no perAck or perErr, busy stays high for TIMEOUT-1 cycles after the request and a fault pulse appears TIMEOUT cycles after the request. A perAck in the last busy cycle still gives done.
- R4: perErr seen while busy gives a fault pulse in the next cycle without waiting for the timeout.
- R5: When perAck and perErr are high in the same busy cycle, the access ends in a fault and done stays low.
- R6: A failed read (error or timeout) raises loadFault. A failed write raises storeFault.
- R7: A write request with byteEn other than 4'b1111 does not raise perWr and does not set busy. storeFault pulses in the next cycle.
- R8: A read request with any byteEn value is forwarded and completes like a full-word read.
- R9: perAck or perErr seen while idle has no effect: no result pulse follows and busy stays low.
- R10: A request made while busy is not forwarded and does not change the outstanding access or its fault type.
- R11: When reqRd and reqWr are high together in the idle state, the write is taken.
- R12: done, loadFault and storeFault are one-cycle pulses. At most one of them is high in any cycle, and each access gives exactly one pulse.
- R13: rstN low asynchronously forces the idle state, with busy, perRd, perWr and all result pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqRd | input | 1 | Read request strobe from the processor |
| reqWr | input | 1 | Write request strobe from the processor |
| byteEn | input | BE_W | Byte-enable mask of the request |
| perAck | input | 1 | Acknowledge from the peripheral |
| perErr | input | 1 | Error answer from the peripheral |
| perRd | output | 1 | Read strobe forwarded to the peripheral |
| perWr | output | 1 | Write strobe forwarded to the peripheral |
| busy | output | 1 | An access is outstanding; new requests are held off |
| done | output | 1 | Access finished successfully |
| loadFault | output | 1 | Read access failed |
| storeFault | output | 1 | Write access failed |

## Verification
The assertions check the following on every cycle:
- no strobe is forwarded while busy;
- a forwarded strobe is followed by busy;
- an acknowledge leads to done, and an error leads to a fault of the matching kind;
- a busy run never exceeds the timeout window, and a fault follows when it runs out;
- a sub-word write is faulted without a strobe;
- result pulses never overlap.

Only the bench scenarios can show the exact latency of each outcome across a range of answer delays. They also show that a request made while busy leaves the pending read's fault type intact, that a simultaneous read and write resolves to the write, and that an asynchronous reset in the middle of an access clears busy.

// File: rtl/pam_pkg.sv
`timescale 1ns/1ps
package pam_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } monStateT;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic start;      // load the wait counter and remember the access kind
    logic startWr;    // kind of the access being started (1 = write)
    logic countUp;    // advance the wait counter
    logic fireDone;   // report success next cycle
    logic fireFault;  // report a fault of the remembered kind next cycle
    logic fireNarrow; // report a store fault for a rejected sub-word write
  } monStrobeT;

  localparam int unsigned FIRST_WAIT_INDEX = 2;

endpackage

// File: rtl/pam_ctrl.sv
`timescale 1ns/1ps
module pam_ctrl
  import pam_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqRd,
  input  logic      reqWr,
  input  logic      fullWord,
  input  logic      perAck,
  input  logic      perErr,
  input  logic      timeoutHit,
  output logic      perRd,
  output logic      perWr,
  output logic      busy,
  output monStrobeT strb
);

  monStateT stateQ;
  monStateT stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    perRd  = 1'b0;
    perWr  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqWr) begin
          // writes win over a simultaneous read
          if (!fullWord) begin
            strb.fireNarrow = 1'b1;
          end else begin
            strb.start   = 1'b1;
            strb.startWr = 1'b1;
            perWr        = 1'b1;
            stateD       = ST_WAIT;
          end
        end else if (reqRd) begin
          strb.start = 1'b1;
          perRd      = 1'b1;
          stateD     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (perErr) begin
          strb.fireFault = 1'b1;
          stateD         = ST_IDLE;
        end else if (perAck) begin
          strb.fireDone = 1'b1;
          stateD        = ST_IDLE;
        end else if (timeoutHit) begin
          strb.fireFault = 1'b1;
          stateD         = ST_IDLE;
        end else begin
          strb.countUp = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ == ST_WAIT);

endmodule

// File: rtl/pam_datapath.sv
`timescale 1ns/1ps
module pam_datapath
  import pam_pkg::*;
#(
  parameter int unsigned TIMEOUT = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  monStrobeT strb,
  output logic      timeoutHit,
  output logic      done,
  output logic      loadFault,
  output logic      storeFault
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  localparam logic [CW-1:0] FIRST = CW'(FIRST_WAIT_INDEX);

  logic [CW-1:0] waitCnt;
  logic          kindWr;

  // waitCnt holds the index of the current cycle within the access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      kindWr  <= 1'b0;
    end else if (strb.start) begin
      waitCnt <= FIRST;
      kindWr  <= strb.startWr;
    end else if (strb.countUp) begin
      waitCnt <= waitCnt + CW'(1);
    end
  end

  assign timeoutHit = (waitCnt >= LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done       <= 1'b0;
      loadFault  <= 1'b0;
      storeFault <= 1'b0;
    end else begin
      done       <= strb.fireDone;
      loadFault  <= strb.fireFault & ~kindWr;
      storeFault <= (strb.fireFault & kindWr) | strb.fireNarrow;
    end
  end

endmodule

// File: rtl/periph_access_monitor.sv
`timescale 1ns/1ps
module periph_access_monitor
  import pam_pkg::*;
#(
  parameter int unsigned TIMEOUT = 15,
  parameter int unsigned BE_W    = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqRd,
  input  logic            reqWr,
  input  logic [BE_W-1:0] byteEn,
  input  logic            perAck,
  input  logic            perErr,
  output logic            perRd,
  output logic            perWr,
  output logic            busy,
  output logic            done,
  output logic            loadFault,
  output logic            storeFault
);

  monStrobeT strb;
  logic      timeoutHit;
  logic      fullWord;

  assign fullWord = &byteEn;

  pam_ctrl ctrlI (
    .clk        (clk),
    .rstN       (rstN),
    .reqRd      (reqRd),
    .reqWr      (reqWr),
    .fullWord   (fullWord),
    .perAck     (perAck),
    .perErr     (perErr),
    .timeoutHit (timeoutHit),
    .perRd      (perRd),
    .perWr      (perWr),
    .busy       (busy),
    .strb       (strb)
  );

  pam_datapath #(.TIMEOUT(TIMEOUT)) dpI (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .timeoutHit (timeoutHit),
    .done       (done),
    .loadFault  (loadFault),
    .storeFault (storeFault)
  );

endmodule

// File: rtl/pam_checker.sv
`timescale 1ns/1ps
module pam_checker #(
  parameter int unsigned TIMEOUT = 15,
  parameter int unsigned BE_W    = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqRd,
  input logic            reqWr,
  input logic [BE_W-1:0] byteEn,
  input logic            perAck,
  input logic            perErr,
  input logic            perRd,
  input logic            perWr,
  input logic            busy,
  input logic            done,
  input logic            loadFault,
  input logic            storeFault
);

  int   runLen;
  logic pendRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= 0;
      pendRd <= 1'b0;
    end else begin
      runLen <= busy ? runLen + 1 : 0;
      if (perRd) pendRd <= 1'b1;
      else if (perWr) pendRd <= 1'b0;
    end
  end

  a_r1_fwd_then_busy: assert property (@(posedge clk) disable iff (!rstN)
    (perRd || perWr) |=> busy);

  a_r2_ack_gives_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && perAck && !perErr) |=> (done && !busy));

  a_r3_busy_window: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen <= int'(TIMEOUT) - 2));

  a_r3_timeout_fault: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runLen == int'(TIMEOUT) - 2 && !perAck && !perErr) |=> (loadFault || storeFault));

  a_r4_err_fault: assert property (@(posedge clk) disable iff (!rstN)
    (busy && perErr) |=> ((loadFault || storeFault) && !done)); // also R5

  a_r6_read_load_fault: assert property (@(posedge clk) disable iff (!rstN)
    (busy && perErr && pendRd) |=> (loadFault && !storeFault));

  a_r7_narrow_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqWr && byteEn != '1) |-> !perWr);

  a_r7_narrow_fault: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqWr && byteEn != '1) |=> (storeFault && !busy));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqRd && !reqWr) |=> (!done && !loadFault && !storeFault && !busy));

  a_r10_holdoff: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!perRd && !perWr));

  a_r12_one_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, loadFault, storeFault}));

endmodule

bind periph_access_monitor pam_checker #(.TIMEOUT(TIMEOUT), .BE_W(BE_W)) chkI (
  .clk        (clk),
  .rstN       (rstN),
  .reqRd      (reqRd),
  .reqWr      (reqWr),
  .byteEn     (byteEn),
  .perAck     (perAck),
  .perErr     (perErr),
  .perRd      (perRd),
  .perWr      (perWr),
  .busy       (busy),
  .done       (done),
  .loadFault  (loadFault),
  .storeFault (storeFault)
);

// File: tb/periph_access_monitor_tb_top.sv
`timescale 1ns/1ps
module periph_access_monitor_tb_top;

  localparam int unsigned TO = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqRd = 1'b0;
  logic       reqWr = 1'b0;
  logic [3:0] byteEn = 4'h0;
  logic       perAck = 1'b0;
  logic       perErr = 1'b0;
  logic       perRd, perWr, busy, done, loadFault, storeFault;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  periph_access_monitor #(.TIMEOUT(TO), .BE_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .reqRd(reqRd), .reqWr(reqWr), .byteEn(byteEn),
    .perAck(perAck), .perErr(perErr), .perRd(perRd), .perWr(perWr),
    .busy(busy), .done(done), .loadFault(loadFault), .storeFault(storeFault)
  );

  // res codes: 0 none, 1 done, 2 load fault, 3 store fault; delay 0 = never
  typedef struct packed {
    logic       wr;
    logic [3:0] be;
    logic [4:0] ackAt;
    logic [4:0] errAt;
    logic [1:0] res;
    logic [4:0] lat;
  } vecT;

  localparam int NV = 12;
  localparam vecT VECS [NV] = '{
    '{1'b0, 4'hF, 5'd1,  5'd0, 2'd1, 5'd2},
    '{1'b1, 4'hF, 5'd1,  5'd0, 2'd1, 5'd2},
    '{1'b0, 4'hF, 5'd4,  5'd0, 2'd1, 5'd5},
    '{1'b1, 4'hF, 5'd0,  5'd1, 2'd3, 5'd2},
    '{1'b0, 4'hF, 5'd0,  5'd3, 2'd2, 5'd4},
    '{1'b0, 4'hF, 5'd2,  5'd2, 2'd2, 5'd3},
    '{1'b1, 4'hF, 5'd0,  5'd0, 2'd3, 5'd15},
    '{1'b0, 4'hF, 5'd0,  5'd0, 2'd2, 5'd15},
    '{1'b0, 4'hF, 5'd14, 5'd0, 2'd1, 5'd15},
    '{1'b1, 4'h3, 5'd1,  5'd0, 2'd3, 5'd1},
    '{1'b0, 4'h1, 5'd1,  5'd0, 2'd1, 5'd2},
    '{1'b1, 4'h0, 5'd0,  5'd0, 2'd3, 5'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runVec(input vecT v);
    bit    fwd;
    string tag;
    int    firstC;
    int    got;
    int    pulses;
    fwd = v.wr ? (v.be == 4'hF) : 1'b1;
    if (v.wr && !fwd) tag = "R7";
    else if (!v.wr && v.be != 4'hF) tag = "R8";
    else if (v.errAt != 0 && v.ackAt == v.errAt) tag = "R5";
    else if (v.errAt != 0) tag = "R4/R6";
    else if (v.ackAt == 0) tag = "R3";
    else tag = "R2";
    @(negedge clk);
    reqRd = !v.wr; reqWr = v.wr; byteEn = v.be;
    #1;
    chk(perWr == (v.wr && fwd) && perRd == !v.wr, "R1 strobe", {perRd, perWr}, {!v.wr, v.wr && fwd});
    firstC = 0; got = 0; pulses = 0;
    for (int c = 1; c <= int'(TO) + 2; c++) begin
      @(negedge clk);
      if (c == 1) chk(busy == fwd, "R1 busy", busy, fwd);
      pulses += int'(done) + int'(loadFault) + int'(storeFault);
      if (firstC == 0 && (done || loadFault || storeFault)) begin
        firstC = c;
        got = done ? 1 : (loadFault ? 2 : 3);
      end
      reqRd = 1'b0; reqWr = 1'b0;
      perAck = (int'(v.ackAt) == c);
      perErr = (int'(v.errAt) == c);
    end
    perAck = 1'b0; perErr = 1'b0;
    chk(got == int'(v.res), {tag, " result"}, got, int'(v.res));
    chk(firstC == int'(v.lat), {tag, " latency"}, firstC, int'(v.lat));
    chk(pulses == 1, "R12 pulse count", pulses, 1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R13 reset state
    repeat (2) @(negedge clk);
    chk({busy, done, loadFault, storeFault, perRd, perWr} == 6'b0, "R13 reset outputs",
        {busy, done, loadFault, storeFault, perRd, perWr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R9: answers while idle are ignored
    @(negedge clk);
    perAck = 1'b1; perErr = 1'b1;
    @(negedge clk);
    perAck = 1'b0; perErr = 1'b0;
    @(negedge clk);
    chk({busy, done, loadFault, storeFault} == 4'b0, "R9 idle answer", {busy, done, loadFault, storeFault}, 0);

    // R10: request while busy is held off and keeps the read kind
    @(negedge clk);
    reqRd = 1'b1; byteEn = 4'hF;
    @(negedge clk);
    reqRd = 1'b0; reqWr = 1'b1;
    #1;
    chk(perWr == 1'b0 && perRd == 1'b0, "R10 no strobe while busy", {perRd, perWr}, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R10 still busy", busy, 1);
    reqWr = 1'b0; perErr = 1'b1;
    @(negedge clk);
    perErr = 1'b0;
    chk(loadFault == 1'b1 && storeFault == 1'b0, "R10 fault kind kept", {loadFault, storeFault}, 2);
    @(negedge clk);

    // R11: simultaneous read and write takes the write
    reqRd = 1'b1; reqWr = 1'b1; byteEn = 4'hF;
    #1;
    chk(perWr == 1'b1 && perRd == 1'b0, "R11 write wins", {perRd, perWr}, 1);
    @(negedge clk);
    reqRd = 1'b0; reqWr = 1'b0; perErr = 1'b1;
    @(negedge clk);
    perErr = 1'b0;
    chk(storeFault == 1'b1 && loadFault == 1'b0, "R11 store fault", {loadFault, storeFault}, 1);
    @(negedge clk);

    // R13: asynchronous reset mid-access
    reqRd = 1'b1;
    @(negedge clk);
    reqRd = 1'b0;
    chk(busy == 1'b1, "R13 busy before reset", busy, 1);
    #1 rstN = 1'b0;
    #1;
    chk(busy == 1'b0, "R13 async clear", busy, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, loadFault, storeFault} == 4'b0, "R13 after reset", {busy, done, loadFault, storeFault}, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule